// File: doc/BRIEF.md
# Embedding gather-reduce engine

This block turns a list of sparse row indices into reduced embedding vectors. Software-side logic sets two base addresses through a small write-only register port. It then appends the lengths of the output segments to an internal list and issues a start write. The engine reads the index array from memory into a local buffer, one 64-byte line at a time. It then issues one 64-byte row read per stored index. Rows are summed lane by lane as they come back, and one reduced vector is emitted per segment.

The memory side is a request port with a ready signal and a response port that returns data in request order, one line per cycle at most. New row reads go out whenever the port accepts them and the count of reads in flight is below a cap. Many reads can therefore overlap. Only the running sum of the current segment is kept, never the rows themselves.

Top module: `emb_gather_reduce`

## Requirements
- R1: A write to register 0 sets the index-array base address, and a write to register 1 sets the table base address. Both writes take effect only while the block is idle. Writes made while busy are dropped, and later jobs keep using the earlier values.
- R2: A write to register 2 appends the written value as the length of the next segment. The append is dropped if the list already holds SEG_MAX entries, or if it would raise the summed length above IDX_DEPTH.
- R3: A write to register 3 while idle starts a job. The block first reads ceil(total/16) index lines at index base + 64*k for k = 0, 1, ... in order. No row read is issued before all of these lines have returned.
- R4: Entry j of index line k sits in bits [32j+31:32j] and is index number 16k+j. Row reads are issued in index order, at address table base + (index << 6).
- R5: At most MAX_OUT reads are in flight, and no request is raised at that cap. A request that is not accepted is held, with the same address, until it is accepted.
- R6: Each output is the lane-wise sum, modulo 2^32, of the 16 signed 32-bit lanes of the segment's rows. Lane j is bits [32j+31:32j]. out_valid is high for one cycle per segment, in segment order, after the last row of that segment has returned.
- R7: A segment of length zero emits an all-zero vector in its place in the order.
- R8: Every segment's sum starts from zero. No row of one segment contributes to another.
- R9: busy is high from the cycle after a start until the job's last output. No request is raised while idle, and out_valid is only high while busy. The lengths list is empty after each job.
- R10: After reset, busy, out_valid and mem_req_valid are low.
- R11: A start with an empty lengths list holds busy high for exactly one cycle. It issues no request and emits no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 index base, 1 table base, 2 append length, 3 start |
| cfg_wdata | input | ADDR_W | Register write data |
| busy | output | 1 | A job is in progress |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | ADDR_W | Byte address of the 64-byte line to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle, in request order |
| mem_rsp_data | input | LANES*LANE_W | Returned line |
| out_valid | output | 1 | One-cycle pulse carrying a reduced vector |
| out_vec | output | LANES*LANE_W | Reduced vector of the finished segment |

## Verification
The assertions assume that memory returns at most one response per cycle, and only for a read that is already in flight. The bench memory keeps to this by queuing each accepted request with a due cycle and releasing them in order, one per cycle. It never holds a response back beyond the engine's need. Register writes are made only between jobs, except for the deliberate writes made while busy. Ready is driven either always high or from a pseudo-random pattern, and latencies are chosen long enough to drive the in-flight count to its cap.

// File: rtl/emb_gather_reduce.sv
module emb_gather_reduce #(
  parameter int LANES     = 16,
  parameter int LANE_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_DEPTH = 64,
  parameter int SEG_MAX   = 8,
  parameter int MAX_OUT   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_addr,
  input  logic [ADDR_W-1:0]       cfg_wdata,
  output logic                    busy,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [LANES*LANE_W-1:0] mem_rsp_data,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] out_vec
);
  localparam int LINE_W  = LANES * LANE_W;
  localparam int LINE_SH = $clog2(LINE_W / 8);
  localparam int LANE_SH = $clog2(LANES);
  localparam int CNT_W   = $clog2(IDX_DEPTH + 1);
  localparam int PTR_W   = $clog2(IDX_DEPTH);
  localparam int SEG_W   = $clog2(SEG_MAX + 1);
  localparam int SI_W    = $clog2(SEG_MAX);
  localparam int OUT_W   = $clog2(MAX_OUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_GATHER} state_t;

  state_t             state;
  logic [ADDR_W-1:0]  idx_base, tbl_base;
  logic [CNT_W-1:0]   len_q [SEG_MAX];
  logic [SEG_W-1:0]   nseg, iseg, seg;
  logic [CNT_W-1:0]   total, f_sent, f_got, irow, ipos, got;
  logic [LANE_W-1:0]  idx_buf [IDX_DEPTH];
  logic [LINE_W-1:0]  acc, sum;
  logic [OUT_W-1:0]   outst;

  logic [CNT_W:0]     tot_ext;
  logic [CNT_W-1:0]   lines_need, i_len, s_len;
  logic               i_live, s_live, i_issue, i_step, f_issue, room, fire;
  logic               idle, go, len_ok;
  logic [LANE_W-1:0]  row_idx;

  assign idle       = (state == S_IDLE);
  assign busy       = !idle;
  assign tot_ext    = {1'b0, total} + (CNT_W+1)'(LANES - 1);
  assign lines_need = CNT_W'(tot_ext >> LANE_SH);

  assign i_live  = iseg < nseg;
  assign s_live  = seg < nseg;
  assign i_len   = i_live ? len_q[iseg[SI_W-1:0]] : '0;
  assign s_len   = s_live ? len_q[seg[SI_W-1:0]] : '0;
  assign i_issue = (state == S_GATHER) && i_live && (ipos < i_len);
  assign i_step  = (state == S_GATHER) && i_live && (ipos == i_len) &&
                   ((i_len != '0) || (seg > iseg));
  assign f_issue = (state == S_FETCH) && (f_sent < lines_need);
  assign room    = outst < OUT_W'(MAX_OUT);

  assign row_idx       = idx_buf[irow[PTR_W-1:0]];
  assign mem_req_valid = (f_issue || i_issue) && room;
  assign mem_req_addr  = f_issue ? idx_base + (ADDR_W'(f_sent) << LINE_SH)
                                 : tbl_base + (ADDR_W'(row_idx) << LINE_SH);
  assign fire          = mem_req_valid && mem_req_ready;

  assign go     = cfg_we && (cfg_addr == 2'd3) && idle;
  assign len_ok = (nseg < SEG_W'(SEG_MAX)) &&
                  (cfg_wdata <= ADDR_W'(IDX_DEPTH) - ADDR_W'(total));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sum[g*LANE_W +: LANE_W] = acc[g*LANE_W +: LANE_W] + mem_rsp_data[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (state == S_FETCH && mem_rsp_valid)
      for (int j = 0; j < LANES; j++)
        idx_buf[PTR_W'(int'(f_got) * LANES + j)] <= mem_rsp_data[j*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst <= '0;
    end else if (fire && !mem_rsp_valid) begin
      outst <= outst + 1'b1;
    end else if (!fire && mem_rsp_valid) begin
      outst <= outst - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx_base  <= '0;
      tbl_base  <= '0;
      nseg      <= '0;
      total     <= '0;
      f_sent    <= '0;
      f_got     <= '0;
      irow      <= '0;
      ipos      <= '0;
      iseg      <= '0;
      seg       <= '0;
      got       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_vec   <= '0;
      for (int s = 0; s < SEG_MAX; s++) len_q[s] <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cfg_we && cfg_addr == 2'd0) idx_base <= cfg_wdata;
          if (cfg_we && cfg_addr == 2'd1) tbl_base <= cfg_wdata;
          if (cfg_we && cfg_addr == 2'd2 && len_ok) begin
            len_q[nseg[SI_W-1:0]] <= CNT_W'(cfg_wdata);
            total <= total + CNT_W'(cfg_wdata);
            nseg  <= nseg + 1'b1;
          end
          if (go) begin
            state  <= (total == '0) ? S_GATHER : S_FETCH;
            f_sent <= '0;
            f_got  <= '0;
            irow   <= '0;
            ipos   <= '0;
            iseg   <= '0;
            seg    <= '0;
            got    <= '0;
            acc    <= '0;
          end
        end
        S_FETCH: begin
          if (fire) f_sent <= f_sent + 1'b1;
          if (mem_rsp_valid) f_got <= f_got + 1'b1;
          if (f_got == lines_need) state <= S_GATHER;
        end
        default: begin
          if (fire) begin
            irow <= irow + 1'b1;
            ipos <= ipos + 1'b1;
          end else if (i_step) begin
            iseg <= iseg + 1'b1;
            ipos <= '0;
          end
          if (!s_live) begin
            state <= S_IDLE;
            nseg  <= '0;
            total <= '0;
          end else if (mem_rsp_valid) begin
            if (got + 1'b1 == s_len) begin
              out_valid <= 1'b1;
              out_vec   <= sum;
              acc       <= '0;
              got       <= '0;
              seg       <= seg + 1'b1;
            end else begin
              acc <= sum;
              got <= got + 1'b1;
            end
          end else if (s_len == '0) begin
            out_valid <= 1'b1;
            out_vec   <= '0;
            seg       <= seg + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/emb_gather_reduce_chk.sv
module emb_gather_reduce_chk #(
  parameter int ADDR_W  = 32,
  parameter int MAX_OUT = 8,
  parameter int OUT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              out_valid,
  input logic [OUT_W-1:0]  outst
);
  a_r5_cap_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> outst < OUT_W'(MAX_OUT));

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r5_rsp_owed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> outst != '0);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r9_out_in_job: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
endmodule

bind emb_gather_reduce emb_gather_reduce_chk #(
  .ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .out_valid(out_valid), .outst(outst)
);

// File: tb/test_emb_gather_reduce.sv
module test_emb_gather_reduce;
  localparam int CAP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic         busy, mem_req_valid, out_valid;
  logic         mem_req_ready = 1'b0;
  logic         mem_rsp_valid = 1'b0;
  logic [31:0]  mem_req_addr;
  logic [511:0] mem_rsp_data = '0;
  logic [511:0] out_vec;

  emb_gather_reduce i_emb_gather_reduce (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  int errors = 0, checks = 0;
  logic [511:0] mem [logic [31:0]];
  logic [31:0]  exp_addr [$];
  logic [511:0] exp_out [$];
  logic [511:0] rsp_q [$];
  longint       rsp_due [$];
  longint       cyc = 0;
  int           lat = 2, rdy_mode = 0, inflight = 0, max_inflight = 0;
  logic [15:0]  lfsr = 16'hACE1;
  string        tag = "R10";
  logic [31:0]  m_ib = '0, m_tb = '0;
  int           jl [$];
  logic [511:0] e_tmp;
  logic [31:0]  a_tmp;
  logic         rdy;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] rowdata(input int idx);
    logic [511:0] r;
    for (int j = 0; j < 16; j++)
      r[j*32 +: 32] = 32'(idx) * 32'h9E3779B1 + 32'(j) * 32'h01000193 + 32'h7FFF_FF00;
    return r;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
    end else begin
      if (out_valid) begin
        if (exp_out.size() == 0) check(1'b0, tag, "unexpected output", out_vec, '0);
        else begin
          e_tmp = exp_out.pop_front();
          check(out_vec === e_tmp, tag, "reduced vector", out_vec, e_tmp);
        end
      end
      if (rsp_q.size() > 0 && rsp_due[0] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rsp_q.pop_front();
        void'(rsp_due.pop_front());
        inflight--;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy  = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
      mem_req_ready = rdy;
      if (mem_req_valid && rdy) begin
        if (exp_addr.size() == 0) check(1'b0, tag, "unexpected request", {480'b0, mem_req_addr}, '0);
        else begin
          a_tmp = exp_addr.pop_front();
          check(mem_req_addr === a_tmp, tag, "request address", {480'b0, mem_req_addr}, {480'b0, a_tmp});
        end
        rsp_q.push_back(mem.exists(mem_req_addr) ? mem[mem_req_addr] : '0);
        rsp_due.push_back(cyc + lat);
        inflight++;
        if (inflight > max_inflight) max_inflight = inflight;
        if (inflight > CAP) check(1'b0, "R5", "reads in flight", 512'(inflight), 512'(CAP));
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_job(input string t, input int l, input int mode, input bit wr_ptr,
                         input logic [31:0] ib, input logic [31:0] tb,
                         input int rej_first, input int rej_last, input bit poke, input int want_cap);
    int total, nlines, k, guard;
    int idx [$];
    logic [511:0] line, s;
    tag = t; lat = l; rdy_mode = mode; inflight = 0; max_inflight = 0;
    if (wr_ptr) begin
      cfg_wr(2'd0, ib); cfg_wr(2'd1, tb);
      m_ib = ib; m_tb = tb;
    end
    total = 0;
    foreach (jl[i]) total += jl[i];
    for (int i = 0; i < total; i++) idx.push_back($urandom_range(0, 255));
    nlines = (total + 15) / 16;
    for (int ln = 0; ln < nlines; ln++) begin
      for (int j = 0; j < 16; j++)
        line[j*32 +: 32] = (ln*16 + j < total) ? 32'(idx[ln*16 + j]) : 32'hDEAD_0000 + 32'(j);
      mem[m_ib + 32'(ln*64)] = line;
      exp_addr.push_back(m_ib + 32'(ln*64));
    end
    foreach (idx[i]) begin
      mem[m_tb + 32'(idx[i]) * 64] = rowdata(idx[i]);
      exp_addr.push_back(m_tb + 32'(idx[i]) * 64);
    end
    k = 0;
    foreach (jl[sg]) begin
      s = '0;
      for (int r = 0; r < jl[sg]; r++) begin
        line = rowdata(idx[k]);
        for (int j = 0; j < 16; j++) s[j*32 +: 32] = s[j*32 +: 32] + line[j*32 +: 32];
        k++;
      end
      exp_out.push_back(s);
    end
    foreach (jl[i]) begin
      cfg_wr(2'd2, 32'(jl[i]));
      if (i == 0 && rej_first >= 0) cfg_wr(2'd2, 32'(rej_first));
    end
    if (rej_last >= 0) cfg_wr(2'd2, 32'(rej_last));
    cfg_wr(2'd3, 32'd0);
    check(busy === 1'b1, "R9", "busy after start", {511'b0, busy}, 512'd1);
    if (poke) begin
      cfg_wr(2'd0, 32'h00F0_0000);
      cfg_wr(2'd1, 32'h0F00_0000);
    end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    check(exp_out.size() == 0, t, "outputs outstanding at end", 512'(exp_out.size()), '0);
    check(exp_addr.size() == 0, t, "requests outstanding at end", 512'(exp_addr.size()), '0);
    if (want_cap > 0)
      check(max_inflight == want_cap, "R5", "peak reads in flight", 512'(max_inflight), 512'(want_cap));
    exp_out.delete(); exp_addr.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R10", "busy in reset", {511'b0, busy}, '0);
    check(out_valid === 1'b0, "R10", "out_valid in reset", {511'b0, out_valid}, '0);
    check(mem_req_valid === 1'b0, "R10", "request in reset", {511'b0, mem_req_valid}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && mem_req_valid === 1'b0, "R10", "idle after reset", {510'b0, busy, mem_req_valid}, '0);

    jl = '{3, 5};
    run_job("R8 R6", 2, 0, 1'b1, 32'h0000_1000, 32'h0010_0000, -1, -1, 1'b0, 0);
    jl = '{0, 12, 0, 0, 9, 0};
    run_job("R7 R5", 12, 0, 1'b0, '0, '0, -1, -1, 1'b0, CAP);
    jl = '{5, 7, 4};
    run_job("R5 R4", 3, 1, 1'b1, 32'h0000_2000, 32'h0020_0000, -1, -1, 1'b1, 0);
    jl = '{60, 4};
    run_job("R1 R2", 4, 1, 1'b0, '0, '0, 5, -1, 1'b0, 0);
    jl = '{8, 8, 8, 8, 8, 8, 8, 8};
    run_job("R3 R2", 1, 0, 1'b1, 32'h0000_4000, 32'h0040_0000, -1, 0, 1'b0, 0);

    tag = "R11";
    cfg_wr(2'd3, 32'd0);
    check(busy === 1'b1, "R11", "busy one cycle", {511'b0, busy}, 512'd1);
    @(negedge clk);
    check(busy === 1'b0, "R11", "idle after empty job", {511'b0, busy}, '0);
    repeat (3) @(negedge clk);

    jl = '{1};
    run_job("R4 R9", 1, 1, 1'b0, '0, '0, -1, -1, 1'b0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule